// File: doc/BRIEF.md
# Wakeup Interrupt Trigger Normaliser

This block sits between a bank of external wakeup interrupt lines and a downstream interrupt controller. That controller accepts only rising-edge pulses or active-high levels. Each line is given a 3-bit trigger type and an enable. The block synchronises each line into the local clock and detects edges and levels. It then re-expresses falling edges, both-edge activity and active-low levels in the single polarity the controller understands. A disabled line, or a line set to an unused type code, stays low.

Software reaches the configuration over a simple word-addressed register bus. Writes carry a per-bit mask, so one field can be changed without disturbing the others. Where each line's enable lives depends on the version the block is built with. In newer builds the enable sits inside each line's configuration word. In older builds it sits in a packed enable bank. A read-only version register reports which build is present.

Changing a line's polarity while its input holds steady would look like a transition after inversion. The block therefore suppresses any edge event in the cycle that follows a configuration change on that line.

Top module: `wake_trig_norm`

## Requirements
- R1: After reset every line is disabled with trigger type 100, every `irq_out` bit is low, and each configuration word reads 0x4.
- R2: Type 100 (level, active high): while enabled, `irq_out[n]` is the input level captured three clock edges earlier (two synchroniser stages plus an output register).
- R3: Type 000 (level, active low): while enabled, `irq_out[n]` is the inverse of that same delayed input level.
- R4: Type 110 (rising edge): each low-to-high input transition yields exactly one single-cycle high pulse on `irq_out[n]`, with the same three-edge latency.
- R5: Type 010 (falling edge): each high-to-low input transition yields one single-cycle high pulse.
- R6: Type 111 (both edges): every input transition, in either direction, yields one single-cycle high pulse.
- R7: A disabled line drives `irq_out[n]` low. The unused codes 001, 011 and 101 also drive it low, whatever the enable.
- R8: Line n's configuration word sits at byte address 0x110 + 4n. Bits [2:0] hold the type. Bit 3 holds the enable when the block is in per-word enable mode. A write changes only the bits whose `bus_wmask` bit is 1.
- R9: When `VERSION_ID` is below 0x30200, enables live in a packed bank at byte address 0x10 + 4*(n/32), bit n%32. In this mode configuration-word bit 3 reads 0 and its writes are ignored. Otherwise the bank reads 0 and its writes are ignored.
- R10: In the cycle after a write changes a line's type or effective enable, no edge-type pulse is produced for that line.
- R11: Byte address 0x1000 reads `VERSION_ID`, and writes to it are ignored. Misaligned addresses, unmapped addresses and unimplemented bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | NUM_LINES | Asynchronous wakeup input lines |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | NUM_LINES | Normalised interrupt lines to the downstream controller |

## Verification
The bench builds two copies with NUM_LINES = 40, driven by the same stimulus. One copy has a version at the per-word-enable threshold; the other has an older version that selects the packed bank. This lets both enable layouts, and the writes each one must ignore, be checked against each other on every cycle. Forty lines make the bank span a full word and a partially used second word. That brings line 33's bit mapping, and the zero-reading upper bits of the second word, within reach. Random writes include unused type codes and partial masks. Random sparse input toggles reach every trigger type. A directed flip from falling to rising type, with the input held high, forces the phantom-edge case.

// File: rtl/wtn_pkg.sv
package wtn_pkg;

  localparam logic [2:0] TRG_LVL_LO = 3'b000;
  localparam logic [2:0] TRG_FALL   = 3'b010;
  localparam logic [2:0] TRG_LVL_HI = 3'b100;
  localparam logic [2:0] TRG_RISE   = 3'b110;
  localparam logic [2:0] TRG_BOTH   = 3'b111;

  localparam logic [31:0] PER_WORD_ENABLE_MIN = 32'h0003_0200;

  function automatic logic trg_invert(input logic [2:0] t);
    return (t == TRG_LVL_LO) || (t == TRG_FALL);
  endfunction

  function automatic logic trg_is_level(input logic [2:0] t);
    return (t == TRG_LVL_LO) || (t == TRG_LVL_HI);
  endfunction

  function automatic logic trg_is_single_edge(input logic [2:0] t);
    return (t == TRG_FALL) || (t == TRG_RISE);
  endfunction

  function automatic logic trg_is_edge(input logic [2:0] t);
    return trg_is_single_edge(t) || (t == TRG_BOTH);
  endfunction

  function automatic logic trg_is_valid(input logic [2:0] t);
    return trg_is_level(t) || trg_is_edge(t);
  endfunction

  function automatic logic trg_fire(input logic [2:0] t, input logic en,
                                    input logic norm, input logic norm_prev,
                                    input logic quiet);
    logic r;
    r = 1'b0;
    if (en) begin
      if (trg_is_level(t))           r = norm;
      else if (trg_is_single_edge(t)) r = norm & ~norm_prev & ~quiet;
      else if (t == TRG_BOTH)         r = (norm ^ norm_prev) & ~quiet;
    end
    return r;
  endfunction

endpackage

// File: rtl/wtn_line.sv
module wtn_line
  import wtn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [2:0] trig,
  input  logic       en,
  input  logic       quiet,
  output logic       irq,
  output logic       norm_lvl
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   norm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], raw};
  end

  assign norm_lvl = chain[SYNC_STAGES-1] ^ trg_invert(trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_prev <= 1'b0;
      irq       <= 1'b0;
    end else begin
      norm_prev <= norm_lvl;
      irq       <= trg_fire(trig, en, norm_lvl, norm_prev, quiet);
    end
  end

endmodule

// File: rtl/wtn_regs.sv
module wtn_regs
  import wtn_pkg::*;
#(
  parameter int          NUM_LINES  = 64,
  parameter int          ADDR_W     = 16,
  parameter logic [31:0] VERSION_ID = 32'h0003_0200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  input  logic [31:0]                wmask,
  output logic [31:0]                rdata,
  output logic [NUM_LINES-1:0][2:0]  trig_o,
  output logic [NUM_LINES-1:0]       en_o,
  output logic [NUM_LINES-1:0]       quiet_o
);

  localparam int  WORD_W     = ADDR_W - 2;
  localparam int  BANK_WORDS = (NUM_LINES + 31) / 32;
  localparam int  BANK_BASE  = 'h10 >> 2;
  localparam int  CFG_BASE   = 'h110 >> 2;
  localparam int  VER_WORD   = 'h1000 >> 2;
  localparam bit  USE_BANK   = (VERSION_ID < PER_WORD_ENABLE_MIN);

  logic [WORD_W-1:0]            word;
  logic                         aligned;
  logic [NUM_LINES-1:0][2:0]    trig_q, trig_d;
  logic [NUM_LINES-1:0]         en_q, en_d, quiet_q;
  logic [BANK_WORDS*32-1:0]     en_pad;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign en_pad  = (BANK_WORDS*32)'(en_q);

  always_comb begin
    trig_d = trig_q;
    en_d   = en_q;
    if (wr_en && aligned) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (word == WORD_W'(CFG_BASE + i)) begin
          trig_d[i] = (trig_q[i] & ~wmask[2:0]) | (wdata[2:0] & wmask[2:0]);
          if (!USE_BANK && wmask[3]) en_d[i] = wdata[3];
        end
        if (USE_BANK && word == WORD_W'(BANK_BASE + i / 32) && wmask[i % 32])
          en_d[i] = wdata[i % 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) trig_q[i] <= TRG_LVL_HI;
      en_q    <= '0;
      quiet_q <= '0;
    end else begin
      trig_q <= trig_d;
      en_q   <= en_d;
      for (int i = 0; i < NUM_LINES; i++)
        quiet_q[i] <= (trig_d[i] != trig_q[i]) || (en_d[i] != en_q[i]);
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(VER_WORD)) rdata = VERSION_ID;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (word == WORD_W'(CFG_BASE + i))
          rdata = {28'h0, (USE_BANK ? 1'b0 : en_q[i]), trig_q[i]};
      end
      for (int w = 0; w < BANK_WORDS; w++) begin
        if (USE_BANK && word == WORD_W'(BANK_BASE + w))
          rdata = en_pad[w*32 +: 32];
      end
    end
  end

  assign trig_o  = trig_q;
  assign en_o    = en_q;
  assign quiet_o = quiet_q;

endmodule

// File: rtl/wake_trig_norm.sv
module wake_trig_norm
  import wtn_pkg::*;
#(
  parameter int          NUM_LINES   = 64,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] VERSION_ID  = 32'h0003_0200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] wake_in,
  input  logic                 bus_wr_en,
  input  logic [15:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [31:0]          bus_wmask,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [NUM_LINES-1:0][2:0] line_trig;
  logic [NUM_LINES-1:0]      line_en;
  logic [NUM_LINES-1:0]      line_quiet;
  logic [NUM_LINES-1:0]      line_norm;

  wtn_regs #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (16),
    .VERSION_ID (VERSION_ID)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .wmask   (bus_wmask),
    .rdata   (bus_rdata),
    .trig_o  (line_trig),
    .en_o    (line_en),
    .quiet_o (line_quiet)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wtn_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (wake_in[g]),
      .trig     (line_trig[g]),
      .en       (line_en[g]),
      .quiet    (line_quiet[g]),
      .irq      (irq_out[g]),
      .norm_lvl (line_norm[g])
    );
  end

endmodule

// File: rtl/wake_trig_norm_chk.sv
module wake_trig_norm_chk
  import wtn_pkg::*;
#(
  parameter int          NUM_LINES  = 64,
  parameter logic [31:0] VERSION_ID = 32'h0003_0200
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [15:0]               bus_addr,
  input logic [31:0]               bus_rdata,
  input logic [NUM_LINES-1:0]      irq_out,
  input logic [NUM_LINES-1:0][2:0] line_trig,
  input logic [NUM_LINES-1:0]      line_en,
  input logic [NUM_LINES-1:0]      line_quiet,
  input logic [NUM_LINES-1:0]      line_norm
);

  AST_OFF_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((irq_out & ~$past(line_en)) == '0)); // R7

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'h1000) |-> (bus_rdata == VERSION_ID)); // R11

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 16'h0110 && bus_addr < 16'(32'h110 + 4 * NUM_LINES))
      |-> (bus_rdata[31:4] == 28'h0)); // R11

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    AST_UNUSED_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !trg_is_valid(line_trig[g]) |=> !irq_out[g]); // R7

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (trg_is_single_edge(line_trig[g]) && irq_out[g]) |=> !irq_out[g]); // R4

    AST_CFG_CHANGE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (line_quiet[g] && trg_is_edge(line_trig[g])) |=> !irq_out[g]); // R10

    AST_LEVEL_TRACKS_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en[g] && trg_is_level(line_trig[g])) |=> (irq_out[g] == $past(line_norm[g]))); // R2
  end

endmodule

bind wake_trig_norm wake_trig_norm_chk #(
  .NUM_LINES  (NUM_LINES),
  .VERSION_ID (VERSION_ID)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .line_trig  (line_trig),
  .line_en    (line_en),
  .line_quiet (line_quiet),
  .line_norm  (line_norm)
);

// File: tb/wake_trig_norm_test.sv
module wake_trig_norm_test;

  localparam int          N    = 40;
  localparam logic [31:0] VER0 = 32'h0003_0200;
  localparam logic [31:0] VER1 = 32'h0002_0100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  wake_in;
  logic          bus_wr_en;
  logic [15:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_wmask;
  logic [31:0]   rd0, rd1;
  logic [N-1:0]  irq0, irq1;

  always #5 clk = ~clk;

  wake_trig_norm #(.NUM_LINES(N), .VERSION_ID(VER0)) uut (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(rd0), .irq_out(irq0));

  wake_trig_norm #(.NUM_LINES(N), .VERSION_ID(VER1)) uut_bank (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(rd1), .irq_out(irq1));

  int checks = 0;
  int fails  = 0;

  logic [2:0]   m_trig [N];
  logic [2:0]   m_trig1[N];
  logic [2:0]   m_trig2[N];
  logic [N-1:0] m_en [2];
  logic [N-1:0] m_en1[2];
  logic [N-1:0] m_q  [2];
  logic [N-1:0] m_q1 [2];
  logic [N-1:0] ih0, ih1, ih2, ih3;

  // Expected output after an edge, from the trigger-type requirements R2-R7, R10
  function automatic logic model_fire(input logic [2:0] t, input logic en,
                                      input logic s, input logic sd,
                                      input logic [2:0] tp, input logic q);
    logic now_lvl, old_lvl;
    now_lvl = (t == 3'b000 || t == 3'b010) ? ~s : s;
    old_lvl = (tp == 3'b000 || tp == 3'b010) ? ~sd : sd;
    if (!en) return 1'b0;
    case (t)
      3'b100, 3'b000: return now_lvl;
      3'b110, 3'b010: return (now_lvl && !old_lvl && !q);
      3'b111:         return ((now_lvl != old_lvl) && !q);
      default:        return 1'b0;
    endcase
  endfunction

  function automatic string req_tag(input logic [2:0] t, input logic en, input logic q);
    if (!en) return "R7";
    case (t)
      3'b100: return "R2";
      3'b000: return "R3";
      3'b110: return q ? "R10" : "R4";
      3'b010: return q ? "R10" : "R5";
      3'b111: return q ? "R10" : "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int d, input logic [15:0] a);
    int word;
    logic [31:0] r;
    r = '0;
    word = int'(a >> 2);
    if (a[1:0] != 2'b00) return '0;
    if (word == 'h400) return (d == 0) ? VER0 : VER1;
    if (word >= 'h44 && word < 'h44 + N)
      return {28'h0, (d == 0) ? m_en[0][word - 'h44] : 1'b0, m_trig[word - 'h44]};
    if (d == 1 && word >= 4 && word < 6) begin
      for (int b = 0; b < 32; b++)
        if ((word - 4) * 32 + b < N) r[b] = m_en[1][(word - 4) * 32 + b];
      return r;
    end
    return '0;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] dat,
                             input logic [31:0] msk);
    int word;
    logic [2:0] nt;
    word = int'(a >> 2);
    if (a[1:0] != 2'b00) return;
    for (int i = 0; i < N; i++) begin
      if (word == 'h44 + i) begin
        nt = (m_trig[i] & ~msk[2:0]) | (dat[2:0] & msk[2:0]);
        if (nt != m_trig[i]) begin
          m_q[0][i] = 1'b1;
          m_q[1][i] = 1'b1;
        end
        m_trig[i] = nt;
        if (msk[3] && m_en[0][i] != dat[3]) begin
          m_en[0][i] = dat[3];
          m_q[0][i]  = 1'b1;
        end
      end
      if (word == 4 + i / 32 && msk[i % 32] && m_en[1][i] != dat[i % 32]) begin
        m_en[1][i] = dat[i % 32];
        m_q[1][i]  = 1'b1;
      end
    end
  endtask

  task automatic step();
    logic exp_v, act_v;
    @(posedge clk);
    m_trig2 = m_trig1;
    m_trig1 = m_trig;
    for (int d = 0; d < 2; d++) begin
      m_en1[d] = m_en[d];
      m_q1[d]  = m_q[d];
      m_q[d]   = '0;
    end
    ih3 = ih2; ih2 = ih1; ih1 = ih0; ih0 = wake_in;
    if (bus_wr_en) model_write(bus_addr, bus_wdata, bus_wmask);
    #1;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < N; i++) begin
        exp_v = model_fire(m_trig1[i], m_en1[d][i], ih2[i], ih3[i], m_trig2[i], m_q1[d][i]);
        act_v = (d == 0) ? irq0[i] : irq1[i];
        checks++;
        if (act_v !== exp_v) begin
          fails++;
          $display("FAIL %s dut%0d line %0d type %b: irq_out=%0b expected %0b",
                   req_tag(m_trig1[i], m_en1[d][i], m_q1[d][i]), d, i, m_trig1[i],
                   act_v, exp_v);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic check_read(input logic [15:0] a, input string tag);
    logic [31:0] e0, e1;
    bus_addr = a;
    #1;
    e0 = model_read(0, a);
    e1 = model_read(1, a);
    checks += 2;
    if (rd0 !== e0) begin
      fails++;
      $display("FAIL %s uut read 0x%h: got 0x%h expected 0x%h", tag, a, rd0, e0);
    end
    if (rd1 !== e1) begin
      fails++;
      $display("FAIL %s uut_bank read 0x%h: got 0x%h expected 0x%h", tag, a, rd1, e1);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] dat,
                           input logic [31:0] msk);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = dat;
    bus_wmask = msk;
    step();
    bus_wr_en = 1'b0;
  endtask

  task automatic expect_word(input logic [31:0] act, input logic [31:0] exp_v,
                             input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got 0x%h expected 0x%h", what, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog: run hung, got no finish expected finish");
    finish_run();
  end

  initial begin
    logic [63:0] rnd;
    int          line;
    int          sel;
    logic [31:0] msk;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_trig[i] = 3'b100; m_trig1[i] = 3'b100; m_trig2[i] = 3'b100;
    end
    for (int d = 0; d < 2; d++) begin
      m_en[d] = '0; m_en1[d] = '0; m_q[d] = '0; m_q1[d] = '0;
    end
    ih0 = '0; ih1 = '0; ih2 = '0; ih3 = '0;
    wake_in = '0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wmask = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_word(32'(irq0), 32'h0, "R1 uut irq_out after reset");
    expect_word(32'(irq1), 32'h0, "R1 uut_bank irq_out after reset");
    check_read(16'h0110, "R1");
    check_read(16'h0110 + 16'(4 * (N - 1)), "R1");
    check_read(16'h0010, "R1");

    // R11: version register, write ignored, unmapped and misaligned reads
    check_read(16'h1000, "R11");
    bus_write(16'h1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check_read(16'h1000, "R11");
    check_read(16'h0800, "R11");
    check_read(16'h0112, "R11");

    // R8: masked type write keeps the enable bit
    bus_write(16'h0110 + 16'd12, 32'h0000_000F, 32'h0000_000F);
    bus_write(16'h0110 + 16'd12, 32'hFFFF_FFF6, 32'h0000_0007);
    check_read(16'h0110 + 16'd12, "R8");
    expect_word(rd0, 32'h0000_000E, "R8 line 3 enable kept after type-only write");

    // R9: packed bank, line 33 maps to word 1 bit 1
    bus_write(16'h0014, 32'h0000_0002, 32'h0000_0002);
    check_read(16'h0014, "R9");
    expect_word(rd1, 32'h0000_0002, "R9 uut_bank bank word 1");
    check_read(16'h0110 + 16'(4 * 33), "R9");
    bus_write(16'h0110 + 16'(4 * 33), 32'h0000_0008, 32'h0000_0008);
    check_read(16'h0110 + 16'(4 * 33), "R9");

    // R10: polarity flip with a steady high input must not fire
    bus_write(16'h0110 + 16'd20, 32'h0000_000E, 32'h0000_000F);
    bus_write(16'h0010, 32'h0000_0020, 32'h0000_0020);
    wake_in[5] = 1'b1;
    repeat (6) step();
    bus_write(16'h0110 + 16'd20, 32'h0000_0002, 32'h0000_0007);
    repeat (4) step();
    bus_write(16'h0110 + 16'd20, 32'h0000_0006, 32'h0000_0007);
    repeat (4) step();
    bus_write(16'h0110 + 16'd20, 32'h0000_0000, 32'h0000_0007);
    repeat (4) step();

    // enable every line in both layouts, then mixed random traffic
    for (int i = 0; i < N; i++)
      bus_write(16'h0110 + 16'(4 * i), 32'h0000_0008 | 32'($urandom_range(7, 0)),
                32'h0000_000F);
    bus_write(16'h0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    bus_write(16'h0014, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    for (int it = 0; it < 3000; it++) begin
      rnd = {$urandom, $urandom} & {$urandom, $urandom};
      wake_in = wake_in ^ rnd[N-1:0];
      sel = $urandom_range(7, 0);
      if (sel == 0) begin
        line = $urandom_range(N - 1, 0);
        case ($urandom_range(3, 0))
          0: msk = 32'h0000_000F;
          1: msk = 32'h0000_0007;
          2: msk = 32'h0000_0008;
          default: msk = $urandom;
        endcase
        bus_write(16'h0110 + 16'(4 * line), $urandom | 32'h0000_0008, msk);
      end else if (sel == 1) begin
        bus_write(16'h0010 + 16'(4 * $urandom_range(1, 0)), $urandom | $urandom, $urandom);
      end else begin
        case ($urandom_range(3, 0))
          0: check_read(16'h0110 + 16'(4 * $urandom_range(N - 1, 0)), "R8");
          1: check_read(16'h0010 + 16'(4 * $urandom_range(1, 0)), "R9");
          2: check_read(16'h1000, "R11");
          default: check_read(16'($urandom_range(16'h1FFF, 0)), "R11");
        endcase
        step();
      end
    end
    finish_run();
  end

endmodule